// File: doc/BRIEF.md
# Two-Byte Conversion Result Read Pointer

This block sits between a converter's result store and a serial host port. It holds one result per channel for a bank of channels. It also holds the read pointer, which is a channel address together with a half-select bit. On every byte-read strobe the block decides which byte goes back to the host and moves the pointer on. In ten-bit mode a channel gives up its upper byte and then its lower byte, and only after that does the channel address step. In eight-bit mode each read returns one byte and steps the channel at once.

The host first sets the pointer with a load, which can start on the lower half and so skip the upper byte. After that it can burst through consecutive bytes without naming them again. A read that names an address must match the pointer. If it does not, the block returns an error pulse and no data. Each channel also keeps a data-valid flag. A fresh result sets the flag, and reading the lower byte consumes it.

Top module: `rp_read_ptr`

## Requirements
- R1: After synchronous reset, `cur_ch`=0, `cur_low`=0, `ch_valid`=0, `rd_valid`=0, `rd_err`=0 and `rd_data`=0, and every stored result is 0.
- R2: In ten-bit mode (`mode8`=0), an accepted read with `cur_low`=0 returns the upper byte, which is result bits [9:2]. The data appears on `rd_data` with `rd_valid`=1 one cycle after the strobe. The pointer then moves to the same channel with `cur_low`=1.
- R3: In ten-bit mode, an accepted read with `cur_low`=1 returns the lower byte, which is result bits [1:0] followed by six zero bits. The pointer then moves to the next channel with `cur_low`=0.
- R4: `ld_en` writes `ld_ch` and `ld_low` into the pointer, and the new value is visible the next cycle. Loading `ld_low`=1 makes the next ten-bit read return the lower byte. A read strobe in the same cycle as a load is dropped, so neither `rd_valid` nor `rd_err` pulses.
- R5: In eight-bit mode (`mode8`=1), every accepted read returns bits [9:2] whatever the value of `cur_low`. It steps the channel and leaves `cur_low`=0. `rd_low` takes no part in the address compare.
- R6: A read with `rd_chk`=0 follows the pointer without any compare. Stepping from the last channel (7) goes to channel 0.
- R7: A read with `rd_chk`=1 is a mismatch when `rd_ch` differs from `cur_ch`, or when in ten-bit mode `rd_low` differs from `cur_low`. A mismatch pulses `rd_err` for one cycle with `rd_valid`=0 and `rd_data`=0, and leaves the pointer and the flags unchanged.
- R8: A converter write (`cv_we`) stores `cv_res` for `cv_ch`. It sets that channel's `ch_valid` bit, which is visible the next cycle. A read in the same cycle still returns the old result.
- R9: An accepted ten-bit lower-byte read clears that channel's `ch_valid` bit. Upper-byte reads and eight-bit reads leave the bit as it is. A converter write to the same channel in the same cycle keeps the bit set.
- R10: `rd_valid` and `rd_err` are never high together. `rd_data` is 0 whenever `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode8 | input | 1 | 1 selects eight-bit readout, 0 selects ten-bit |
| cv_we | input | 1 | Converter result write strobe |
| cv_ch | input | 3 | Channel of the converter write |
| cv_res | input | 10 | Converter result |
| ld_en | input | 1 | Pointer load strobe |
| ld_ch | input | 3 | Channel to load into the pointer |
| ld_low | input | 1 | Half to load, where 1 is the lower byte |
| rd_req | input | 1 | Byte-read strobe |
| rd_chk | input | 1 | Compare the requested address against the pointer |
| rd_ch | input | 3 | Requested channel |
| rd_low | input | 1 | Requested half |
| rd_valid | output | 1 | Read byte is valid (one-cycle pulse) |
| rd_data | output | 8 | Returned byte |
| rd_err | output | 1 | Address mismatch (one-cycle pulse) |
| cur_ch | output | 3 | Current channel address |
| cur_low | output | 1 | Next read returns the lower byte |
| ch_valid | output | 8 | Per-channel data-valid flags |

## Verification
Every result is due exactly one clock edge after its stimulus. This covers the read byte, the error pulse, the pointer move, the flag change and a load. The bench drives inputs on the falling edge and lets one rising edge pass. It then samples all outputs on the next falling edge and compares them against a bench model that was stepped once for the same inputs. Same-cycle collisions are driven on purpose so that the exact-cycle priority is checked. These are a load with a read, and a converter write with a lower-byte read of the same channel.

// File: rtl/rp_pkg.sv
package rp_pkg;
    parameter int RP_NCH    = 8;
    parameter int RP_RES_W  = 10;
    parameter int RP_BYTE_W = 8;

    localparam int RP_CH_W  = $clog2(RP_NCH);
    localparam int RP_LOW_W = RP_RES_W - RP_BYTE_W;
    localparam int RP_PAD_W = RP_BYTE_W - RP_LOW_W;

    typedef logic [RP_CH_W-1:0]   ch_t;
    typedef logic [RP_RES_W-1:0]  res_t;
    typedef logic [RP_BYTE_W-1:0] byte_t;

    typedef struct packed {
        ch_t  ch;
        logic low;
    } rd_ptr_t;

    typedef enum logic [1:0] {
        RK_IDLE,
        RK_DATA,
        RK_ERR,
        RK_LOAD
    } rd_kind_e;

    typedef struct packed {
        logic  valid;
        logic  err;
        byte_t data;
    } rd_resp_t;

    function automatic byte_t hi_byte(input res_t r);
        return r[RP_RES_W-1 -: RP_BYTE_W];
    endfunction

    function automatic byte_t lo_byte(input res_t r);
        return {r[RP_LOW_W-1:0], {RP_PAD_W{1'b0}}};
    endfunction

    function automatic ch_t next_ch(input ch_t c);
        if (c == ch_t'(RP_NCH - 1))
            return '0;
        return c + ch_t'(1);
    endfunction

    function automatic rd_ptr_t ptr_step(input rd_ptr_t p, input logic m8);
        rd_ptr_t n;
        if (m8 || p.low) begin
            n.ch  = next_ch(p.ch);
            n.low = 1'b0;
        end else begin
            n.ch  = p.ch;
            n.low = 1'b1;
        end
        return n;
    endfunction
endpackage

// File: rtl/rp_store.sv
module rp_store
    import rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  ch_t               wch,
    input  res_t              wres,
    input  ch_t               sel_ch,
    output res_t              sel_res,
    input  logic              clr_en,
    input  ch_t               clr_ch,
    output logic [RP_NCH-1:0] dv
);
    res_t res_arr [RP_NCH];

    for (genvar g = 0; g < RP_NCH; g++) begin : g_ch
        res_t r_q;
        logic v_q;
        logic hit_w;
        logic hit_c;

        assign hit_w = we && (wch == ch_t'(g));
        assign hit_c = clr_en && (clr_ch == ch_t'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
                v_q <= 1'b0;
            end else begin
                if (hit_w)
                    r_q <= wres;
                if (hit_w)
                    v_q <= 1'b1;
                else if (hit_c)
                    v_q <= 1'b0;
            end
        end

        assign res_arr[g] = r_q;
        assign dv[g]      = v_q;
    end

    assign sel_res = res_arr[sel_ch];

    // R8: a converter write leaves the channel flagged valid
    a_r8_dv_set: assert property (@(posedge clk) disable iff (rst)
        we |=> dv[$past(wch)]);

    // R9: a lower-byte read clears the flag unless a write collides
    a_r9_dv_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(we && wch == clr_ch)) |=> !dv[$past(clr_ch)]);
endmodule

// File: rtl/rp_pointer.sv
module rp_pointer
    import rp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mode8,
    input  logic     ld_en,
    input  ch_t      ld_ch,
    input  logic     ld_low,
    input  logic     rd_req,
    input  logic     rd_chk,
    input  ch_t      rd_ch,
    input  logic     rd_low,
    output rd_ptr_t  ptr,
    output rd_kind_e kind,
    output logic     clr_en
);
    rd_ptr_t ptr_q;
    rd_ptr_t ptr_d;
    logic    mism;

    always_comb begin
        mism = rd_chk && ((rd_ch != ptr_q.ch) || (!mode8 && (rd_low != ptr_q.low)));
        if (ld_en)
            kind = RK_LOAD;
        else if (rd_req)
            kind = mism ? RK_ERR : RK_DATA;
        else
            kind = RK_IDLE;
    end

    always_comb begin
        ptr_d = ptr_q;
        case (kind)
            RK_LOAD: begin
                ptr_d.ch  = ld_ch;
                ptr_d.low = ld_low;
            end
            RK_DATA: ptr_d = ptr_step(ptr_q, mode8);
            default: ptr_d = ptr_q;
        endcase
    end

    assign clr_en = (kind == RK_DATA) && !mode8 && ptr_q.low;

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else
            ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R4: a load lands in the pointer one cycle later
    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (ptr_q.ch == $past(ld_ch)) && (ptr_q.low == $past(ld_low)));

    // R7: a mismatched addressed read leaves the pointer alone
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !ld_en && rd_chk && rd_ch != ptr_q.ch) |=> $stable(ptr_q));

    // R2: a ten-bit upper read moves to the lower half of the same channel
    a_r2_hi_to_lo: assert property (@(posedge clk) disable iff (rst)
        (kind == RK_DATA && !mode8 && !ptr_q.low) |=>
            (ptr_q.low && ptr_q.ch == $past(ptr_q.ch)));

    // R5: eight-bit reads always leave the half bit cleared
    a_r5_m8_low: assert property (@(posedge clk) disable iff (rst)
        (kind == RK_DATA && mode8) |=> !ptr_q.low);
endmodule

// File: rtl/rp_out.sv
module rp_out
    import rp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rd_kind_e kind,
    input  logic     mode8,
    input  logic     ptr_low,
    input  res_t     res,
    output rd_resp_t resp
);
    rd_resp_t resp_d;
    rd_resp_t resp_q;

    always_comb begin
        resp_d = '0;
        case (kind)
            RK_DATA: begin
                resp_d.valid = 1'b1;
                resp_d.data  = (mode8 || !ptr_low) ? hi_byte(res) : lo_byte(res);
            end
            RK_ERR:  resp_d.err = 1'b1;
            default: resp_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            resp_q <= '0;
        else
            resp_q <= resp_d;
    end

    assign resp = resp_q;

    // R10: a silent cycle carries a zero byte
    a_r10_zero_idle: assert property (@(posedge clk) disable iff (rst)
        !resp_q.valid |-> (resp_q.data == '0));
endmodule

// File: rtl/rp_read_ptr.sv
module rp_read_ptr
    import rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode8,
    input  logic              cv_we,
    input  logic [RP_CH_W-1:0]  cv_ch,
    input  logic [RP_RES_W-1:0] cv_res,
    input  logic              ld_en,
    input  logic [RP_CH_W-1:0]  ld_ch,
    input  logic              ld_low,
    input  logic              rd_req,
    input  logic              rd_chk,
    input  logic [RP_CH_W-1:0]  rd_ch,
    input  logic              rd_low,
    output logic              rd_valid,
    output logic [RP_BYTE_W-1:0] rd_data,
    output logic              rd_err,
    output logic [RP_CH_W-1:0]  cur_ch,
    output logic              cur_low,
    output logic [RP_NCH-1:0]   ch_valid
);
    rd_ptr_t  ptr;
    rd_kind_e kind;
    logic     clr_en;
    res_t     sel_res;
    rd_resp_t resp;

    rp_pointer u_ptr (
        .clk    (clk),
        .rst    (rst),
        .mode8  (mode8),
        .ld_en  (ld_en),
        .ld_ch  (ld_ch),
        .ld_low (ld_low),
        .rd_req (rd_req),
        .rd_chk (rd_chk),
        .rd_ch  (rd_ch),
        .rd_low (rd_low),
        .ptr    (ptr),
        .kind   (kind),
        .clr_en (clr_en)
    );

    rp_store u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (cv_we),
        .wch     (cv_ch),
        .wres    (cv_res),
        .sel_ch  (ptr.ch),
        .sel_res (sel_res),
        .clr_en  (clr_en),
        .clr_ch  (ptr.ch),
        .dv      (ch_valid)
    );

    rp_out u_out (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .mode8   (mode8),
        .ptr_low (ptr.low),
        .res     (sel_res),
        .resp    (resp)
    );

    assign rd_valid = resp.valid;
    assign rd_err   = resp.err;
    assign rd_data  = resp.data;
    assign cur_ch   = ptr.ch;
    assign cur_low  = ptr.low;

    // R10: data and error pulses are exclusive
    a_r10_excl: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && rd_err));

    // R6: stepping past the last channel wraps to channel zero
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (kind == RK_DATA && ptr.ch == ch_t'(RP_NCH - 1) && (mode8 || ptr.low))
            |=> (cur_ch == '0));

    // R3: a lower-byte read produces a valid pulse next cycle
    a_r3_lo_valid: assert property (@(posedge clk) disable iff (rst)
        (kind == RK_DATA && !mode8 && ptr.low) |=> (rd_valid && !rd_err));
endmodule

// File: tb/rp_read_ptr_tb.sv
module rp_read_ptr_tb;
    import rp_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode8 = 1'b0;
    logic cv_we = 1'b0;
    logic [2:0] cv_ch = '0;
    logic [9:0] cv_res = '0;
    logic ld_en = 1'b0;
    logic [2:0] ld_ch = '0;
    logic ld_low = 1'b0;
    logic rd_req = 1'b0;
    logic rd_chk = 1'b0;
    logic [2:0] rd_ch = '0;
    logic rd_low = 1'b0;
    logic rd_valid;
    logic [7:0] rd_data;
    logic rd_err;
    logic [2:0] cur_ch;
    logic cur_low;
    logic [7:0] ch_valid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [9:0] m_res [8];
    logic [7:0] m_dv;
    logic [2:0] m_ch;
    logic m_low;
    logic e_valid, e_err;
    logic [7:0] e_data;

    always #2 clk = ~clk;

    rp_read_ptr u_dut (
        .clk(clk), .rst(rst), .mode8(mode8),
        .cv_we(cv_we), .cv_ch(cv_ch), .cv_res(cv_res),
        .ld_en(ld_en), .ld_ch(ld_ch), .ld_low(ld_low),
        .rd_req(rd_req), .rd_chk(rd_chk), .rd_ch(rd_ch), .rd_low(rd_low),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
        .cur_ch(cur_ch), .cur_low(cur_low), .ch_valid(ch_valid)
    );

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_res[i] = '0;
        m_dv = '0; m_ch = '0; m_low = 1'b0;
        e_valid = 1'b0; e_err = 1'b0; e_data = '0;
    endtask

    task automatic model_step();
        logic mism;
        logic [2:0] och;
        logic clr;
        e_valid = 1'b0; e_err = 1'b0; e_data = '0; clr = 1'b0;
        och = m_ch;
        if (ld_en) begin
            m_ch = ld_ch; m_low = ld_low;
        end else if (rd_req) begin
            mism = rd_chk && ((rd_ch != m_ch) || (!mode8 && rd_low != m_low));
            if (mism) e_err = 1'b1;
            else begin
                e_valid = 1'b1;
                if (mode8 || !m_low) e_data = m_res[m_ch][9:2];
                else e_data = {m_res[m_ch][1:0], 6'b0};
                clr = !mode8 && m_low;
                if (mode8 || m_low) begin
                    m_ch = m_ch + 3'd1; m_low = 1'b0;
                end else m_low = 1'b1;
            end
        end
        if (clr) m_dv[och] = 1'b0;
        if (cv_we) begin
            m_dv[cv_ch] = 1'b1; m_res[cv_ch] = cv_res;
        end
    endtask

    task automatic compare(input string tag);
        total++;
        if ({rd_valid, rd_err, rd_data, cur_ch, cur_low, ch_valid} !==
            {e_valid, e_err, e_data, m_ch, m_low, m_dv}) begin
            bad++;
            $display("FAIL %s: got v=%b e=%b d=%h ch=%0d lo=%b dv=%b exp v=%b e=%b d=%h ch=%0d lo=%b dv=%b",
                tag, rd_valid, rd_err, rd_data, cur_ch, cur_low, ch_valid,
                e_valid, e_err, e_data, m_ch, m_low, m_dv);
        end
    endtask

    task automatic cyc(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        cv_we = 1'b0; ld_en = 1'b0; rd_req = 1'b0; rd_chk = 1'b0;
    endtask

    task automatic wr(input logic [2:0] c, input logic [9:0] r);
        cv_we = 1'b1; cv_ch = c; cv_res = r;
    endtask

    task automatic ld(input logic [2:0] c, input logic l);
        ld_en = 1'b1; ld_ch = c; ld_low = l;
    endtask

    task automatic rd(input logic chk, input logic [2:0] c, input logic l);
        rd_req = 1'b1; rd_chk = chk; rd_ch = c; rd_low = l;
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R1 reset");

        mode8 = 1'b0;
        wr(3'd3, 10'h2A7); cyc("R8 write ch3");
        ld(3'd3, 1'b0); cyc("R4 load ch3 high");
        rd(1'b1, 3'd3, 1'b0); cyc("R2 upper byte");
        rd(1'b1, 3'd3, 1'b1); cyc("R3 lower byte R9 clear");
        rd(1'b1, 3'd2, 1'b0); cyc("R7 channel mismatch");
        rd(1'b1, 3'd4, 1'b1); cyc("R7 half mismatch");
        wr(3'd5, 10'h3FF); cyc("R8 write ch5");
        ld(3'd5, 1'b1); cyc("R4 load skip upper");
        rd(1'b0, 3'd0, 1'b0); cyc("R4 skipped read returns lower");
        ld(3'd7, 1'b0); cyc("R4 load ch7");
        rd(1'b0, 3'd0, 1'b0); cyc("R6 burst upper");
        rd(1'b0, 3'd0, 1'b0); cyc("R6 wrap to 0");
        wr(3'd7, 10'h155); cyc("R8 write ch7");
        mode8 = 1'b1;
        ld(3'd7, 1'b1); cyc("R5 load in 8-bit");
        rd(1'b1, 3'd7, 1'b0); cyc("R5 8-bit ignores half");
        rd(1'b0, 3'd0, 1'b0); cyc("R5 8-bit advance");
        mode8 = 1'b0;
        wr(3'd1, 10'h0C3); cyc("R8 write ch1");
        ld(3'd1, 1'b1); cyc("R4 load ch1 low");
        rd(1'b1, 3'd1, 1'b1); wr(3'd1, 10'h301); cyc("R9 write beats clear");
        ld(3'd2, 1'b0); rd(1'b0, 3'd0, 1'b0); cyc("R4 load drops read");
        rd(1'b0, 3'd0, 1'b0); cyc("R10 idle data zero");

        void'($urandom(32'h5eed_0042));
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'd0) mode8 = ~mode8;
            if (r[6:4] < 3'd2) wr(3'($urandom), 10'($urandom));
            if (r[9:7] == 3'd0) ld(3'($urandom), 1'($urandom));
            if (r[12:10] < 3'd5) begin
                if (r[14:13] == 2'd0) rd(1'b1, 3'($urandom), 1'($urandom));
                else rd(r[15], m_ch, m_low);
            end
            cyc("R7 R9 random mix");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1: got hang exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule